// File: doc/BRIEF.md
# Three-Wire Serial Register Master

This block is the host side of a three-wire register bus. The bus has an active-low select line, a serial clock that the master produces, and one data line that both sides share. A local requester presents an operation flag, a 7-bit register address and a 16-bit write word for one cycle. The master then runs the complete serial transaction and reports completion with a one-cycle pulse. On a read, the returned 16-bit word is presented with that pulse.

The serial clock comes from dividing the system clock. The default divide ratio is the smallest whole half-period that keeps the serial clock at or below 19.2 MHz. The target on this bus has no clock of its own, so every transaction begins with a clock edge that precedes the select. A write ends with a clock edge that follows the select, which lets the target commit the word. The shared line comes out as a separate output value and output-enable pair, so the pad ring can build the tristate buffer.

Top module: `tw_master`

## Requirements
- R1: After reset and between transactions, select is high, the serial clock is low, the data-line output enable is low, and busy and done are low.
- R2: Each serial clock level lasts HALF system cycles. The default HALF is the smallest value that keeps SYS_KHZ / (2*HALF) at or below MAX_SCLK_KHZ (4 for 125 MHz).
- R3: A transaction starts with one rising serial clock edge while select is still high (rise 0). Select drops together with the following falling edge.
- R4: Rises 1 to 9 carry, in order, a start bit of 1, an operation bit (1 = read, 0 = write) and the address most significant bit first, with output enable high. The driven value changes only together with a falling serial clock edge.
- R5: On a write, rises 10 to 25 carry the 16 data bits most significant bit first, with output enable high throughout.
- R6: On a write, select rises together with falling edge 25. Exactly one more rising edge (rise 26) follows with select high. Done pulses at falling edge 26, so a write has 27 rising edges.
- R7: On a read, output enable drops together with falling edge 9 and stays low through the last data rise (rise 27). The first data rise is rise 12, three rises after the last address rise.
- R8: On a read, the data line is sampled at falling edges 12 to 27, most significant bit first. Select rises and done pulses at falling edge 27, so a read has 28 rising edges. The sampled word appears on rd_data in the same cycle as done.
- R9: Done is high for exactly one system cycle per transaction. Busy is high from the cycle after acceptance until done.
- R10: A request that arrives while busy is ignored. It does not change the frame in progress, and no transaction starts for it afterwards.
- R11: rd_data keeps the last read word; a write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last word read |
| tw_en_n | output | 1 | Active-low select |
| tw_sclk | output | 1 | Serial clock |
| tw_sdo | output | 1 | Value driven onto the data line |
| tw_sdo_oe | output | 1 | Output enable for the data line |
| tw_sdi | input | 1 | Data line as seen at the pad |

## Verification
The bench models the target with one rise counter and checks the corner cases edge by edge. A master that lowered select too early would lose the leading edge, and the target would miss its first bit. A master that skipped the trailing edge would leave the written word uncommitted. A master that released the line late on a read would fight the target at rise 12. A master that sampled on the rising edge would return a word shifted by one bit. Alternating and all-ones words, together with the extreme addresses, expose bit order and off-by-one shift errors. Requests injected in mid-frame show whether a master restarts or corrupts a transaction in progress. A write placed after a read shows whether the held read word survives.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } tw_state_e;

   function automatic int half_for(input int sys_khz, input int max_khz);
      return (sys_khz + 2 * max_khz - 1) / (2 * max_khz);
   endfunction
endpackage

// File: rtl/tw_tick_gen.sv
module tw_tick_gen #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (HALF == 1) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (!run)       cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                 cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == LAST);
   end
endmodule

// File: rtl/tw_sequencer.sv
module tw_sequencer
   import tw_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16,
   parameter int TURN   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_rd,
   input  logic tick,
   output logic run,
   output logic sclk,
   output logic en_n,
   output logic oe,
   output logic fin,
   output logic tx_step,
   output logic rx_step,
   output logic rx_last
);
   localparam int PW = $clog2(ADDR_W + DATA_W + TURN + 4);
   localparam logic [PW-1:0] F_HDR_LAST = PW'(ADDR_W + 1);
   localparam logic [PW-1:0] F_WR_LAST  = PW'(ADDR_W + DATA_W + 1);
   localparam logic [PW-1:0] F_WR_ENH   = PW'(ADDR_W + DATA_W + 2);
   localparam logic [PW-1:0] F_WR_END   = PW'(ADDR_W + DATA_W + 3);
   localparam logic [PW-1:0] F_RD_REL   = PW'(ADDR_W + 2);
   localparam logic [PW-1:0] F_RD_FIRST = PW'(ADDR_W + 2 + TURN);
   localparam logic [PW-1:0] F_RD_LAST  = PW'(ADDR_W + 1 + TURN + DATA_W);

   tw_state_e     state;
   logic [PW-1:0] per;
   logic          rd_q;
   logic          fall;

   assign run     = (state == ST_RUN);
   assign fall    = run && tick && sclk;
   assign tx_step = fall && ((per <= F_HDR_LAST) || (!rd_q && per <= F_WR_LAST));
   assign rx_step = fall && rd_q && (per >= F_RD_FIRST) && (per <= F_RD_LAST);
   assign rx_last = rx_step && (per == F_RD_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         per   <= '0;
         rd_q  <= 1'b0;
         sclk  <= 1'b0;
         en_n  <= 1'b1;
         oe    <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (state == ST_IDLE) begin
            if (start) begin
               state <= ST_RUN;
               per   <= '0;
               rd_q  <= start_rd;
               sclk  <= 1'b0;
            end
         end else if (tick) begin
            if (!sclk) begin
               sclk <= 1'b1;
            end else begin
               sclk <= 1'b0;
               per  <= per + 1'b1;
               if (per == '0) begin
                  en_n <= 1'b0;
                  oe   <= 1'b1;
               end
               if (!rd_q && per == F_WR_ENH) begin
                  en_n <= 1'b1;
                  oe   <= 1'b0;
               end
               if (!rd_q && per == F_WR_END) begin
                  fin   <= 1'b1;
                  state <= ST_IDLE;
               end
               if (rd_q && per == F_RD_REL) oe <= 1'b0;
               if (rd_q && per == F_RD_LAST) begin
                  en_n  <= 1'b1;
                  fin   <= 1'b1;
                  state <= ST_IDLE;
               end
            end
         end
      end
   end
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_rd,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_wdata,
   input  logic              tx_step,
   input  logic              rx_step,
   input  logic              rx_last,
   input  logic              sdi,
   output logic              sdo,
   output logic [DATA_W-1:0] rd_data
);
   localparam int FRAME_W = 2 + ADDR_W + DATA_W;

   logic [FRAME_W-1:0] txsr;
   logic [DATA_W-1:0]  rxsr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txsr <= '0;
         sdo  <= 1'b0;
      end else if (load) begin
         txsr <= {1'b1, load_rd, load_addr, load_wdata};
         sdo  <= 1'b0;
      end else if (tx_step) begin
         sdo  <= txsr[FRAME_W-1];
         txsr <= {txsr[FRAME_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxsr    <= '0;
         rd_data <= '0;
      end else if (rx_step) begin
         rxsr <= {rxsr[DATA_W-2:0], sdi};
         if (rx_last) rd_data <= {rxsr[DATA_W-2:0], sdi};
      end
   end
endmodule

// File: rtl/tw_master.sv
module tw_master
   import tw_pkg::*;
#(
   parameter int SYS_KHZ      = 125000,
   parameter int MAX_SCLK_KHZ = 19200,
   parameter int HALF         = half_for(SYS_KHZ, MAX_SCLK_KHZ),
   parameter int ADDR_W       = 7,
   parameter int DATA_W       = 16,
   parameter int TURN         = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_read,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              tw_en_n,
   output logic              tw_sclk,
   output logic              tw_sdo,
   output logic              tw_sdo_oe,
   input  logic              tw_sdi
);
   if (HALF < 1) begin : g_bad_half
      $error("HALF must be at least 1");
   end
   if (SYS_KHZ > 2 * HALF * MAX_SCLK_KHZ) begin : g_bad_rate
      $error("serial clock would exceed MAX_SCLK_KHZ");
   end
   if (ADDR_W < 1 || DATA_W < 2 || TURN < 1) begin : g_bad_shape
      $error("ADDR_W, DATA_W or TURN out of range");
   end

   logic start, tick, run, tx_step, rx_step, rx_last;

   assign start = req_valid && !run;
   assign busy  = run;

   tw_tick_gen #(.HALF(HALF)) u_tick (
      .clk (clk),
      .rst_n (rst_n),
      .run (run),
      .tick (tick)
   );

   tw_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN(TURN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .start_rd (req_read),
      .tick     (tick),
      .run      (run),
      .sclk     (tw_sclk),
      .en_n     (tw_en_n),
      .oe       (tw_sdo_oe),
      .fin      (done),
      .tx_step  (tx_step),
      .rx_step  (rx_step),
      .rx_last  (rx_last)
   );

   tw_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sh (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .load_rd    (req_read),
      .load_addr  (req_addr),
      .load_wdata (req_wdata),
      .tx_step    (tx_step),
      .rx_step    (rx_step),
      .rx_last    (rx_last),
      .sdi        (tw_sdi),
      .sdo        (tw_sdo),
      .rd_data    (rd_data)
   );
endmodule

// File: rtl/tw_chk.sv
module tw_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic done,
   input logic tw_en_n,
   input logic tw_sclk,
   input logic tw_sdo,
   input logic tw_sdo_oe
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (tw_en_n && !tw_sclk && !tw_sdo_oe));

   p_en_with_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tw_en_n) |-> $fell(tw_sclk));

   p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tw_sdo_oe && $past(tw_sdo_oe) && !$stable(tw_sdo)) |-> $fell(tw_sclk));

   p_oe_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tw_sdo_oe |-> !tw_en_n);

   p_oe_off_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tw_sdo_oe) |-> $fell(tw_sclk));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_start_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));
endmodule

bind tw_master tw_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .tw_en_n   (tw_en_n),
   .tw_sclk   (tw_sclk),
   .tw_sdo    (tw_sdo),
   .tw_sdo_oe (tw_sdo_oe)
);

// File: tb/sim_tw_master.sv
`timescale 1ns/1ps
module sim_tw_master;
   localparam int HALF_EXP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_read = 1'b0;
   logic [6:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic busy, done;
   logic [15:0] rd_data;
   logic tw_en_n, tw_sclk, tw_sdo, tw_sdo_oe;
   logic tw_sdi = 1'b0;

   int checks = 0, errors = 0;
   int cyc = 0;
   int rise_n = 0;
   int done_cnt = 0;
   logic en_at [0:31], oe_at [0:31], sdo_at [0:31];
   int   cyc_at [0:31];
   logic tgt_rd = 1'b0;
   logic [15:0] tgt_val = '0;
   logic [15:0] done_rd = '0;
   logic [15:0] last_rd = '0;

   always #4 clk = ~clk;

   tw_master u0 (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_read (req_read),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .busy (busy), .done (done), .rd_data (rd_data),
      .tw_en_n (tw_en_n), .tw_sclk (tw_sclk),
      .tw_sdo (tw_sdo), .tw_sdo_oe (tw_sdo_oe), .tw_sdi (tw_sdi)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (done) begin
         done_cnt = done_cnt + 1;
         done_rd  = rd_data;
      end
   end

   // target model: records the bus at each rising edge, drives read bits
   always @(posedge tw_sclk) begin
      if (rise_n < 32) begin
         en_at[rise_n]  = tw_en_n;
         oe_at[rise_n]  = tw_sdo_oe;
         sdo_at[rise_n] = tw_sdo;
         cyc_at[rise_n] = cyc;
      end
      if (tgt_rd && rise_n >= 12 && rise_n <= 27) tw_sdi = tgt_val[27 - rise_n];
      rise_n = rise_n + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_hdr(input logic rd, input logic [6:0] a);
      return {1'b1, rd, a};
   endfunction

   task automatic txn(input logic rd, input logic [6:0] a, input logic [15:0] wd,
                      input logic [15:0] rv, input bit poke);
      logic [8:0]  hdr_act;
      logic [15:0] dat_act;
      logic [17:0] oe_rd;
      bit          gap_ok;
      int          wait_n;
      int          rises_at_done;
      rise_n = 0; done_cnt = 0; tgt_rd = rd; tgt_val = rv;
      @(negedge clk);
      req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R9 busy after accept", {31'd0, busy}, 32'd1);
      if (poke) begin
         repeat (40) @(negedge clk);
         req_valid = 1'b1; req_read = ~rd; req_addr = ~a; req_wdata = ~wd;
         @(negedge clk);
         req_valid = 1'b0;
      end
      wait_n = 0;
      while (done_cnt == 0 && wait_n < 3000) begin
         @(negedge clk);
         wait_n = wait_n + 1;
      end
      rises_at_done = rise_n;
      repeat (30) @(negedge clk);
      chk(done_cnt == 1, "R9 single done pulse", done_cnt, 32'd1);
      chk(busy == 1'b0 && tw_en_n && !tw_sclk && !tw_sdo_oe, "R1 idle after done",
          {28'd0, busy, tw_en_n, tw_sclk, tw_sdo_oe}, 32'h4);
      chk(rise_n == rises_at_done, "R10 no restart after done", rise_n, rises_at_done);
      chk(en_at[0] == 1'b1 && en_at[1] == 1'b0, "R3 leading edge before select",
          {30'd0, en_at[0], en_at[1]}, 32'h2);
      hdr_act = '0;
      for (int i = 0; i < 9; i++) hdr_act[8-i] = sdo_at[1+i];
      chk(hdr_act == exp_hdr(rd, a), poke ? "R10 R4 header under mid-frame request" : "R4 header",
          {23'd0, hdr_act}, {23'd0, exp_hdr(rd, a)});
      gap_ok = 1'b1;
      for (int k = 0; k < rise_n - 1 && k < 31; k++)
         if (cyc_at[k+1] - cyc_at[k] != 2 * HALF_EXP) gap_ok = 1'b0;
      chk(gap_ok, "R2 serial clock period", cyc_at[1] - cyc_at[0], 2 * HALF_EXP);
      if (!rd) begin
         dat_act = '0;
         for (int i = 0; i < 16; i++) dat_act[15-i] = sdo_at[10+i];
         chk(dat_act == wd, "R5 write data", {16'd0, dat_act}, {16'd0, wd});
         gap_ok = 1'b1;
         for (int i = 1; i <= 25; i++) if (!oe_at[i] || en_at[i]) gap_ok = 1'b0;
         chk(gap_ok, "R5 line driven whole write", 32'd0, 32'd1);
         chk(rise_n == 27 && en_at[26] == 1'b1, "R6 trailing commit edge", rise_n, 32'd27);
         chk(rd_data == last_rd, "R11 write keeps read word", {16'd0, rd_data}, {16'd0, last_rd});
      end else begin
         oe_rd = '0;
         for (int i = 10; i <= 27; i++) oe_rd[i-10] = oe_at[i];
         chk(oe_rd == '0 && oe_at[9] == 1'b1, "R7 line released for read", {14'd0, oe_rd}, 32'd0);
         chk(rise_n == 28 && en_at[27] == 1'b0, "R8 read edge count", rise_n, 32'd28);
         chk(done_rd == rv, "R8 read word at done", {16'd0, done_rd}, {16'd0, rv});
         last_rd = rv;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      chk(tw_en_n && !tw_sclk && !tw_sdo_oe && !done && !busy, "R1 reset state",
          {27'd0, tw_en_n, tw_sclk, tw_sdo_oe, done, busy}, 32'h10);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(tw_en_n && !tw_sclk && !busy && rd_data == 16'h0, "R1 idle after reset",
          {15'd0, tw_en_n, rd_data}, 32'h10000);
      txn(1'b0, 7'h00, 16'hFFFF, 16'h0000, 1'b0);
      txn(1'b0, 7'h7F, 16'h0000, 16'h0000, 1'b0);
      txn(1'b1, 7'h55, 16'h0000, 16'h8001, 1'b0);
      txn(1'b0, 7'h2A, 16'hAAAA, 16'h0000, 1'b1);
      txn(1'b1, 7'h2A, 16'h0000, 16'hFFFF, 1'b1);
      txn(1'b0, 7'h01, 16'h5555, 16'h0000, 1'b0);
      for (int n = 0; n < 36; n++) begin
         logic        r;
         logic [6:0]  a;
         logic [15:0] w, v;
         bit          p;
         r = 1'($urandom % 2);
         a = 7'($urandom);
         w = 16'($urandom);
         v = 16'($urandom);
         p = (($urandom % 4) == 0);
         txn(r, a, w, v, p);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule